// File: doc/BRIEF.md
# Auto-Reload Square-Wave Clock Output Timer

This block is an up-counting timer with automatic reload. It divides the oscillator clock into a square wave with equal high and low times. Software sets it up through a small register write port that holds a control byte and a reload value, split into bytes. The counter advances once every two oscillator clocks. When it passes its all-ones value, it loads the reload value in that same step. In clock-out mode, each of these rollovers flips an output flop, so the output frequency is the oscillator frequency divided by 4 × (2^CNT_W − reload).

The rollover is also sent out as a one-cycle strobe for a baud-rate divider. That divider shares the reload value, so the two rates can only be chosen together. A second strobe is the timer interrupt request. It fires on rollovers only when clock-out mode is off. When clock-out mode is off, the pin goes back to its ordinary I/O value.

Top module: `clkout_gen`

## Requirements
- R1: While clock-out mode is on and the timer runs, `clk_out` stays high and stays low for 2 × (2^CNT_W − reload) clocks each, which gives a 50% duty cycle.
- R2: Clock-out mode is on exactly when out_en (control bit 2) is 1 and ct_sel (control bit 1) is 0. `pin_oe` is 1 exactly when the mode is on.
- R3: With run (control bit 0) at 0, the count holds. No rollover happens and `clk_out` does not change.
- R4: `irq_stb` pulses for one cycle on a rollover when clock-out mode is off, and never pulses on a rollover while clock-out mode is on.
- R5: `roll_stb` pulses for one cycle on every rollover, whatever the mode.
- R6: A write to the reload bytes does not alter the count. The new value is loaded at the next rollover, so the half-period in progress keeps its old length.
- R7: While clock-out mode is off, `clk_out` follows `io_val` and the toggle flop is cleared. On re-entry to the mode, the first output level is 0.
- R8: After reset, the control and reload registers and the count are 0, `pin_oe`, `roll_stb` and `irq_stb` are 0, and `clk_out` equals `io_val`.
- R9: With ct_sel at 1, the count holds even when run is 1, because this block has no external count source.
- R10: Register map: address 0 holds the control byte (bit 0 run, bit 1 ct_sel, bit 2 out_en). Addresses 1 to CNT_W/DATA_W hold the reload bytes, least significant byte first. A write happens on a clock where `wr_en` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | DATA_W | Register write data |
| io_val | input | 1 | Ordinary I/O value for the pin |
| clk_out | output | 1 | Pin value: square wave or I/O value |
| pin_oe | output | 1 | Pin override enable, high in clock-out mode |
| roll_stb | output | 1 | One-cycle rollover strobe for the baud consumer |
| irq_stb | output | 1 | One-cycle timer interrupt request |

## Verification
The bench builds the block with DATA_W = 4 and CNT_W = 8, so the reload is two 4-bit bytes and one full count cycle is 256 steps. Both ends of the reload range are then reachable in a short run: reload 0x00 gives a half-period of 512 clocks, and reload 0xFF gives 2 clocks. A mid-period reload write, a stop, both disabling paths and re-entry can each be checked against a clock-by-clock model within a few thousand cycles.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  typedef struct packed {
    logic out_en;
    logic ct_sel;
    logic run;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/clkout_rst_sync.sv
module clkout_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/clkout_regs.sv
module clkout_regs
  import clkout_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NBYTES = 2,
  parameter int unsigned ADDR_W = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  output ctrl_t                      ctrl_o,
  output logic [NBYTES*DATA_W-1:0]   reload_o
);
  ctrl_t ctrl_q, ctrl_d;
  logic  ctrl_en;

  // control byte sits at address 0
  always_comb begin
    ctrl_en = wr_en && (wr_addr == '0);
    ctrl_d  = ctrl_t'(wr_data[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  // reload bytes at addresses 1..NBYTES, least significant first
  for (genvar b = 0; b < NBYTES; b++) begin : g_rld
    logic [DATA_W-1:0] byte_q;
    logic              byte_en;

    always_comb byte_en = wr_en && (wr_addr == ADDR_W'(b + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       byte_q <= '0;
      else if (byte_en) byte_q <= wr_data;
    end

    assign reload_o[b*DATA_W +: DATA_W] = byte_q;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/clkout_prescale.sv
module clkout_prescale (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  logic phase_q, phase_d;

  always_comb phase_d = ~phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     phase_q <= 1'b0;
    else if (run_i) phase_q <= phase_d;
  end

  // one count step every second running clock
  assign tick_o = run_i & phase_q;
endmodule

// File: rtl/clkout_counter.sv
module clkout_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             roll_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // rollover loads the reload value in place of zero
  always_comb begin
    roll_o = tick_i & (&cnt_q);
    cnt_d  = roll_o ? reload_i : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/clkout_gen.sv
module clkout_gen
  import clkout_pkg::*;
#(
  parameter  int unsigned DATA_W = 8,
  parameter  int unsigned CNT_W  = 16,
  localparam int unsigned NBYTES = CNT_W / DATA_W,
  localparam int unsigned ADDR_W = $clog2(NBYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              io_val,
  output logic              clk_out,
  output logic              pin_oe,
  output logic              roll_stb,
  output logic              irq_stb
);
  logic             rst_sync_n;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload;
  logic             run_eff, mode, tick, roll;
  logic             tog_q, tog_d, roll_q, roll_d, irq_q, irq_d;

  clkout_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  clkout_regs #(.DATA_W(DATA_W), .NBYTES(NBYTES), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl_o(ctrl), .reload_o(reload)
  );

  always_comb begin
    run_eff = ctrl.run & ~ctrl.ct_sel;
    mode    = ctrl.out_en & ~ctrl.ct_sel;
  end

  clkout_prescale u_pre (.clk(clk), .rst_n(rst_sync_n), .run_i(run_eff), .tick_o(tick));

  clkout_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .tick_i(tick), .reload_i(reload), .roll_o(roll)
  );

  always_comb begin
    tog_d  = mode & (tog_q ^ roll);
    roll_d = roll;
    irq_d  = roll & ~mode;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tog_q  <= 1'b0;
      roll_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      tog_q  <= tog_d;
      roll_q <= roll_d;
      irq_q  <= irq_d;
    end
  end

  assign pin_oe   = mode;
  assign clk_out  = mode ? tog_q : io_val;
  assign roll_stb = roll_q;
  assign irq_stb  = irq_q;
endmodule

// File: rtl/clkout_gen_chk.sv
module clkout_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic run_eff,
  input logic pin_oe,
  input logic clk_out,
  input logic roll_stb,
  input logic irq_stb
);
  // R4
  irq_not_in_clkout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_stb |-> !$past(pin_oe));

  // R4
  irq_needs_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_stb |-> roll_stb);

  // R1
  toggle_on_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe && $past(pin_oe) && (clk_out != $past(clk_out))) |-> roll_stb);

  // R3
  stopped_no_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    roll_stb |-> $past(run_eff));

  // R7
  reentry_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_oe) |-> !clk_out);
endmodule

bind clkout_gen clkout_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run_eff(run_eff), .pin_oe(pin_oe),
  .clk_out(clk_out), .roll_stb(roll_stb), .irq_stb(irq_stb)
);

// File: tb/test_clkout_gen.sv
module test_clkout_gen;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 4;
  localparam int CW   = 8;
  localparam int AW   = 2;
  localparam int MAXV = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          io_val = 1'b1;
  logic          clk_out, pin_oe, roll_stb, irq_stb;

  int n_cmp = 0;
  int n_bad = 0;
  int n_roll = 0;
  int n_irq = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkout_gen #(.DATA_W(DW), .CNT_W(CW)) i_clkout_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .io_val(io_val), .clk_out(clk_out), .pin_oe(pin_oe), .roll_stb(roll_stb),
    .irq_stb(irq_stb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_run, m_cts, m_oe, m_rld, m_cnt, m_ph, m_tog, m_roll, m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_cts = 0; m_oe = 0; m_rld = 0; m_cnt = 0;
      m_ph = 0; m_tog = 0; m_roll = 0; m_irq = 0;
    end else begin
      int running, mode_on, step, rolled;
      running = (m_run != 0) && (m_cts == 0);
      mode_on = (m_oe != 0) && (m_cts == 0);
      step    = running && (m_ph == 1);
      rolled  = step && (m_cnt == MAXV);
      if (rolled)    m_cnt = m_rld;
      else if (step) m_cnt = m_cnt + 1;
      if (running) m_ph = 1 - m_ph;
      if (!mode_on)    m_tog = 0;
      else if (rolled) m_tog = 1 - m_tog;
      m_roll = rolled;
      m_irq  = rolled && !mode_on;
      if (wr_en) begin
        if (wr_addr == 0) begin
          m_run = wr_data[0]; m_cts = wr_data[1]; m_oe = wr_data[2];
        end else if (wr_addr == 1) m_rld = (m_rld & 'hF0) | int'(wr_data);
        else if (wr_addr == 2)     m_rld = (m_rld & 'h0F) | (int'(wr_data) << 4);
      end
    end
  end

  // clock-by-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int mode_on, exp_out;
      mode_on = (m_oe != 0) && (m_cts == 0);
      exp_out = mode_on ? m_tog : int'(io_val);
      chk(pin_oe == mode_on[0], "R2 pin_oe", pin_oe, mode_on);
      chk(clk_out == exp_out[0], "R1 clk_out", clk_out, exp_out);
      chk(roll_stb == m_roll[0], "R5 roll_stb", roll_stb, m_roll);
      chk(irq_stb == m_irq[0], "R4 irq_stb", irq_stb, m_irq);
      if (roll_stb) n_roll++;
      if (irq_stb)  n_irq++;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic set_reload(input int v);
    wr(1, v & 'hF);
    wr(2, (v >> 4) & 'hF);
  endtask

  task automatic wait_toggle(output int n);
    logic v;
    v = clk_out;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (clk_out == v && n < 2000);
  endtask

  task automatic check_halves(input int rld, input string req);
    int n, exp;
    exp = 2 * (MAXV + 1 - rld);
    wait_toggle(n);
    wait_toggle(n);
    chk(n == exp, req, n, exp);
    wait_toggle(n);
    chk(n == exp, req, n, exp);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int n;
    logic v;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R8 reset state
    chk(pin_oe == 1'b0, "R8 pin_oe", pin_oe, 0);
    chk(clk_out == io_val, "R8 clk_out", clk_out, io_val);
    chk(roll_stb == 1'b0 && irq_stb == 1'b0, "R8 strobes", roll_stb, 0);

    // R10 R1: reload 0xF0, run + out_en
    set_reload('hF0);
    wr(0, 5);
    check_halves('hF0, "R1 reload F0");

    // R6: mid-period reload change
    wait_toggle(n);
    set_reload('hFE);
    wait_toggle(n);
    chk(n == 2 * (MAXV + 1 - 'hF0) - 4, "R6 old period kept", n, 2 * (MAXV + 1 - 'hF0) - 4);
    wait_toggle(n);
    chk(n == 4, "R6 new period", n, 4);

    // R1 range ends
    set_reload('hFF);
    check_halves('hFF, "R1 reload FF");
    set_reload('h00);
    check_halves('h00, "R1 reload 00");

    // R4 R5: clock-out mode suppresses irq, roll strobes present
    set_reload('hF8);
    wait_toggle(n); wait_toggle(n);
    n_roll = 0; n_irq = 0;
    repeat (200) @(negedge clk);
    chk(n_irq == 0, "R4 no irq in clock-out", n_irq, 0);
    chk(n_roll > 0, "R5 roll strobes", n_roll, 1);

    // R3: stop, count holds
    wr(0, 4);
    v = clk_out; n_roll = 0; n = 0;
    repeat (150) begin
      @(negedge clk);
      if (clk_out != v) n++;
    end
    chk(n == 0, "R3 no toggle while stopped", n, 0);
    chk(n_roll == 0, "R3 no roll while stopped", n_roll, 0);

    // R2 R7 R4: timer running without clock-out
    wr(0, 1);
    chk(pin_oe == 1'b0, "R2 out_en off", pin_oe, 0);
    @(negedge clk); #1 io_val = 1'b0;
    @(negedge clk);
    chk(clk_out == 1'b0, "R7 follows io_val", clk_out, 0);
    #1 io_val = 1'b1;
    @(negedge clk);
    chk(clk_out == 1'b1, "R7 follows io_val", clk_out, 1);
    n_irq = 0; n_roll = 0;
    repeat (200) @(negedge clk);
    chk(n_irq > 0 && n_irq == n_roll, "R4 irq when not clock-out", n_irq, n_roll);

    // R9 R2: ct_sel holds count
    wr(0, 7);
    chk(pin_oe == 1'b0, "R2 ct_sel blocks mode", pin_oe, 0);
    n_roll = 0;
    repeat (200) @(negedge clk);
    chk(n_roll == 0, "R9 ct_sel holds count", n_roll, 0);

    // R7 re-entry starts low
    #1 io_val = 1'b1;
    wr(0, 5);
    chk(clk_out == 1'b0, "R7 re-entry low", clk_out, 0);
    check_halves('hF8, "R1 after re-entry");

    finish_run();
  end
endmodule